// File: doc/BRIEF.md
# Serial Burst Register Port

This block is a slave serial port that lets an external host read and write an internal file of 256 eight-bit registers. The host pulls chip select low and sends a frame. The frame opens with an address byte. A command byte follows, holding the transfer direction and a byte count. The data bytes come last, as many as the count says. Several frames may follow one another while chip select stays low.

One configuration input, `msb_first`, sets two things at once. The first is the bit order of every word on the wire. The second is the direction in which the burst address moves. With the input high, the address received is the top of the block and the address counts down. With it low, the address received is the bottom of the block and the address counts up.

The port runs on a fast system clock. It synchronises the serial clock, chip select and enable inputs, and it acts on each detected rising edge of the serial clock. At that edge it samples `sdi` and launches the next `sdo` bit. A separate parallel port gives direct combinational read access to the register file.

Top module: `serial_burst_port`

## Requirements
- R1: A frame is one address byte, then one command byte, then the data bytes. Command bit 7 = 1 selects a write and bit 7 = 0 selects a read. Command bits 6:0 give the number of data bytes.
- R2: With `msb_first` = 1, address, command and data words are all shifted bit 7 first.
- R3: With `msb_first` = 0, address, command and data words are all shifted bit 0 first.
- R4: With `msb_first` = 1, data byte k of a burst uses register (address − k).
- R5: With `msb_first` = 0, data byte k of a burst uses register (address + k).
- R6: A count of 1 moves exactly one data byte. A count of 0 behaves like a count of 1.
- R7: Burst addresses wrap modulo 256, from 0xFF to 0x00 when counting up and from 0x00 to 0xFF when counting down.
- R8: In a read, each data bit is launched on a serial clock rising edge, starting with the first rising edge after the command byte. The value of each register is fetched whole before its first bit goes out. At any time when no read data is being shifted out, `sdo` is 0.
- R9: Raising `cs_n` aborts a frame in progress. Nothing is written for a data byte that was only partly received, `sdo` returns to 0, and the next frame starts with an address byte.
- R10: While `spi_en` is low, serial traffic writes nothing and `sdo` stays 0.
- R11: After the last data byte of a frame, with `cs_n` still low, the next byte is taken as a new address.
- R12: After reset, `sdo` is 0 and the port waits for an address byte.
- R13: `dbg_data` always shows the register selected by `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| spi_en | input | 1 | Serial programming enable; frames are ignored while it is low |
| msb_first | input | 1 | Bit order and burst address direction (1: MSB first, counting down) |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| dbg_addr | input | 8 | Register index for the direct read port |
| dbg_data | output | 8 | Contents of the register at `dbg_addr` |

## Verification
The assertions take four things for granted about the inputs. `sck` must stay low or high for several `clk` cycles at a time. `sdi` must be steady across each detected rising edge. `msb_first` and `spi_en` may change only while `cs_n` is high. Frames must be sent whole unless chip select is raised on purpose to abort one. The stimulus meets these conditions in four ways:
- It holds each serial clock phase for six system clocks.
- It changes `sdi` only while `sck` is low.
- It sets the two configuration inputs only between chip-select windows.
- It produces every partial frame deliberately, by raising chip select part-way through a data byte.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int CNT_W  = DATA_W - 1;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_CMD  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RV    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RV;
        else        stage_q[s] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RV;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sbp_regfile.sv
module sbp_regfile
  import sbp_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/sbp_ctrl.sv
module sbp_ctrl
  import sbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              act,
  input  logic              sdi,
  input  logic              msb_first,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output phase_e            phase,
  output logic [CNT_W-1:0]  count,
  output logic              is_write
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  phase_e            ph_q, ph_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [DATA_W-1:0] sh_q, sh_n, tx_q, tx_n, rx_next;
  logic [ADDR_W-1:0] addr_q, addr_n, addr_step;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cmd_cnt;
  logic              wr_q, wr_n, sdo_q, sdo_n, last_bit;

  assign rx_next   = msb_first ? {sh_q[DATA_W-2:0], sdi} : {sdi, sh_q[DATA_W-1:1]};
  assign addr_step = msb_first ? addr_q - 1'b1 : addr_q + 1'b1;
  assign last_bit  = (bit_q == LAST_BIT);
  assign cmd_cnt   = (rx_next[CNT_W-1:0] == '0) ? CNT_W'(1) : rx_next[CNT_W-1:0];
  assign rd_addr   = (ph_q == PH_DATA) ? addr_step : addr_q;

  always_comb begin
    ph_n   = ph_q;
    bit_n  = bit_q;
    sh_n   = sh_q;
    tx_n   = tx_q;
    addr_n = addr_q;
    cnt_n  = cnt_q;
    wr_n   = wr_q;
    sdo_n  = sdo_q;
    if (!act) begin
      ph_n  = PH_ADDR;
      bit_n = '0;
      sdo_n = 1'b0;
    end else if (rise) begin
      bit_n = bit_q + 1'b1;
      sh_n  = rx_next;
      sdo_n = 1'b0;
      unique case (ph_q)
        PH_ADDR: begin
          if (last_bit) begin
            addr_n = rx_next;
            ph_n   = PH_CMD;
          end
        end
        PH_CMD: begin
          if (last_bit) begin
            wr_n  = rx_next[DATA_W-1];
            cnt_n = cmd_cnt;
            tx_n  = rd_data;
            ph_n  = PH_DATA;
          end
        end
        PH_DATA: begin
          if (!wr_q) sdo_n = msb_first ? tx_q[LAST_BIT - bit_q] : tx_q[bit_q];
          if (last_bit) begin
            addr_n = addr_step;
            cnt_n  = cnt_q - 1'b1;
            tx_n   = rd_data;
            if (cnt_q == CNT_W'(1)) ph_n = PH_ADDR;
          end
        end
        default: ph_n = PH_ADDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_ADDR;
      bit_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      tx_q   <= tx_n;
      addr_q <= addr_n;
      cnt_q  <= cnt_n;
      wr_q   <= wr_n;
      sdo_q  <= sdo_n;
    end
  end

  assign wr_en    = act && rise && (ph_q == PH_DATA) && wr_q && last_bit;
  assign wr_addr  = addr_q;
  assign wr_data  = rx_next;
  assign sdo      = sdo_q;
  assign phase    = ph_q;
  assign count    = cnt_q;
  assign is_write = wr_q;
endmodule

// File: rtl/serial_burst_port.sv
module serial_burst_port
  import sbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_en,
  input  logic              msb_first,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  logic [1:0]        rst_q;
  logic              rst_i;
  logic [2:0]        sync_q;
  logic              sck_prev_q, rise, act;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;
  phase_e            phase;
  logic [CNT_W-1:0]  count;
  logic              is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  sbp_sync #(.W(3), .STAGES(SYNC_STAGES), .RV(3'b010)) sync_i (
    .clk  (clk),
    .rst_n(rst_i),
    .d    ({spi_en, cs_n, sck}),
    .q    (sync_q)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sck_prev_q <= 1'b0;
    else        sck_prev_q <= sync_q[0];
  end

  assign rise = sync_q[0] & ~sck_prev_q;
  assign act  = sync_q[2] & ~sync_q[1];

  sbp_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_i),
    .rise     (rise),
    .act      (act),
    .sdi      (sdi),
    .msb_first(msb_first),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sdo      (sdo),
    .phase    (phase),
    .count    (count),
    .is_write (is_write)
  );

  sbp_regfile regs_i (
    .clk    (clk),
    .we     (wr_en),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .raddr_a(rd_addr),
    .rdata_a(rd_data),
    .raddr_b(dbg_addr),
    .rdata_b(dbg_data)
  );
endmodule

// File: rtl/serial_burst_port_chk.sv
module serial_burst_port_chk
  import sbp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             act,
  input logic             wr_en,
  input phase_e           phase,
  input logic [CNT_W-1:0] count,
  input logic             is_write,
  input logic             sdo
);
  // R9
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !sdo);

  // R10
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> act);

  // R1
  write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (is_write && phase == PH_DATA));

  // R1
  frame_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD && $past(phase) != PH_CMD) |-> $past(phase) == PH_ADDR);

  // R6
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DATA |-> count != '0);

  // R8
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !rise) |=> $stable(sdo));
endmodule

bind serial_burst_port serial_burst_port_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_i),
  .rise    (rise),
  .act     (act),
  .wr_en   (wr_en),
  .phase   (phase),
  .count   (count),
  .is_write(is_write),
  .sdo     (sdo)
);

// File: tb/serial_burst_port_tb_top.sv
module serial_burst_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, spi_en, msb_first, cs_n, sck, sdi;
  logic       sdo;
  logic [7:0] dbg_addr, dbg_data;

  always #10 clk = ~clk;

  serial_burst_port dut_i (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .msb_first(msb_first),
    .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  typedef struct { string tag; logic [7:0] val; } exp_t;
  exp_t       exp_q[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] wbuf [4];
  logic [7:0] obs_byte;
  logic [7:0] last_rd;
  event       got_ev;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] v);
    exp_t e;
    e.tag = tag;
    e.val = v;
    exp_q.push_back(e);
  endtask

  // monitor: compares each byte read from the port against the scoreboard
  always begin
    @(got_ev);
    if (exp_q.size() == 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8: unexpected read byte got %02h expected none", obs_byte);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, obs_byte, e.val);
    end
  end

  task automatic bit_io(input logic b, output logic o);
    @(negedge clk);
    sdi = b;
    repeat (6) @(negedge clk);
    sck = 1'b1;
    repeat (6) @(negedge clk);
    o = sdo;
    sck = 1'b0;
  endtask

  task automatic byte_io(input logic [7:0] v, input logic msb, output logic [7:0] r, input int nbits);
    r = '0;
    for (int i = 0; i < nbits; i++) begin
      int  idx;
      logic o;
      idx = msb ? 7 - i : i;
      bit_io(v[idx], o);
      r[idx] = o;
    end
  endtask

  task automatic cs_begin(input logic msb);
    msb_first = msb;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input logic msb, input logic [7:0] addr, input logic [7:0] cmd,
                       input int nbytes, input logic mon);
    logic [7:0] r;
    byte_io(addr, msb, r, 8);
    byte_io(cmd, msb, r, 8);
    for (int k = 0; k < nbytes; k++) begin
      byte_io(cmd[7] ? wbuf[k] : 8'h00, msb, r, 8);
      last_rd = r;
      if (!cmd[7] && mon) begin
        obs_byte = r;
        -> got_ev;
      end
    end
  endtask

  task automatic wr_txn(input logic msb, input logic [7:0] addr, input int n);
    cs_begin(msb);
    frame(msb, addr, 8'h80 | 8'(n), n, 1'b0);
    cs_end();
  endtask

  task automatic rd_txn(input logic msb, input logic [7:0] addr, input int n);
    cs_begin(msb);
    frame(msb, addr, 8'(n), n, 1'b1);
    cs_end();
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [7:0] e);
    @(negedge clk);
    dbg_addr = a;
    #1;
    check(tag, dbg_data, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; spi_en = 1'b1; msb_first = 1'b1; cs_n = 1'b1;
    sck = 1'b0; sdi = 1'b0; dbg_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R12 sdo after reset", {7'b0, sdo}, 8'h00);

    // R2 R4: MSB-first write burst counts down from the block end
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    wr_txn(1'b1, 8'h20, 3);
    chk_reg("R4 msb burst byte0", 8'h20, 8'hA1);
    chk_reg("R4 msb burst byte1", 8'h1F, 8'hB2);
    chk_reg("R2 msb burst byte2", 8'h1E, 8'hC3);

    // R8: MSB-first read burst
    expect_rd("R8 msb read byte0", 8'hA1);
    expect_rd("R8 msb read byte1", 8'hB2);
    expect_rd("R8 msb read byte2", 8'hC3);
    rd_txn(1'b1, 8'h20, 3);

    // R3 R5: LSB-first write burst counts up from the block start
    wbuf[0] = 8'h11; wbuf[1] = 8'h26; wbuf[2] = 8'h3C;
    wr_txn(1'b0, 8'h40, 3);
    chk_reg("R5 lsb burst byte0", 8'h40, 8'h11);
    chk_reg("R5 lsb burst byte1", 8'h41, 8'h26);
    chk_reg("R3 lsb burst byte2", 8'h42, 8'h3C);
    expect_rd("R3 lsb read byte0", 8'h11);
    expect_rd("R3 lsb read byte1", 8'h26);
    expect_rd("R3 lsb read byte2", 8'h3C);
    rd_txn(1'b0, 8'h40, 3);
    expect_rd("R2 msb read of lsb-written reg", 8'h26);
    rd_txn(1'b1, 8'h41, 1);

    // R6: count 1 and count 0 each move one byte
    wbuf[0] = 8'h5A;
    wr_txn(1'b1, 8'h5F, 1);
    wbuf[0] = 8'h66; wbuf[1] = 8'hEE;
    cs_begin(1'b1);
    frame(1'b1, 8'h60, 8'h80, 1, 1'b0);
    cs_end();
    chk_reg("R6 count0 writes addr", 8'h60, 8'h66);
    chk_reg("R6 count0 neighbour untouched", 8'h5F, 8'h5A);
    chk_reg("R6 count1 single byte", 8'h5F, 8'h5A);
    expect_rd("R6 count0 read", 8'h66);
    cs_begin(1'b1);
    frame(1'b1, 8'h60, 8'h00, 1, 1'b1);
    cs_end();

    // R7: wrap at both ends
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    wr_txn(1'b0, 8'hFF, 2);
    chk_reg("R7 up wrap FF", 8'hFF, 8'hE1);
    chk_reg("R7 up wrap 00", 8'h00, 8'hE2);
    wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
    wr_txn(1'b1, 8'h00, 2);
    chk_reg("R7 down wrap 00", 8'h00, 8'hD1);
    chk_reg("R7 down wrap FF", 8'hFF, 8'hD2);

    // R9: abort part-way through a data byte
    wbuf[0] = 8'h07;
    wr_txn(1'b1, 8'h70, 1);
    cs_begin(1'b1);
    byte_io(8'h70, 1'b1, r, 8);
    byte_io(8'h82, 1'b1, r, 8);
    byte_io(8'hF0, 1'b1, r, 4);
    cs_end();
    check("R9 sdo after abort", {7'b0, sdo}, 8'h00);
    wbuf[0] = 8'h17;
    wr_txn(1'b1, 8'h71, 1);
    chk_reg("R9 aborted byte not written", 8'h70, 8'h07);
    chk_reg("R9 next frame starts at address", 8'h71, 8'h17);

    // R10: enable low blocks writes and reads
    wbuf[0] = 8'h03;
    wr_txn(1'b1, 8'h30, 1);
    spi_en = 1'b0;
    wbuf[0] = 8'h99;
    wr_txn(1'b1, 8'h30, 1);
    cs_begin(1'b1);
    frame(1'b1, 8'h30, 8'h01, 1, 1'b0);
    cs_end();
    check("R10 sdo quiet when disabled", last_rd, 8'h00);
    spi_en = 1'b1;
    chk_reg("R10 write ignored when disabled", 8'h30, 8'h03);

    // R11: back-to-back frames in one chip-select window
    cs_begin(1'b1);
    wbuf[0] = 8'hA0;
    frame(1'b1, 8'h10, 8'h81, 1, 1'b0);
    wbuf[0] = 8'hB0;
    frame(1'b1, 8'h11, 8'h81, 1, 1'b0);
    cs_end();
    chk_reg("R11 first frame", 8'h10, 8'hA0);
    chk_reg("R11 second frame", 8'h11, 8'hB0);
    chk_reg("R13 direct read", 8'h1E, 8'hC3);

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8: got %0d unread items expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule